// File: doc/BRIEF.md
# Millisecond Time Base with Elapsed Counter and Countdown Timer

This block keeps time for a multiprogrammed processor. It advances two counters on a shared millisecond strobe. The first is a 36-bit up-counter that measures elapsed time, for accounting and for stamping events. Software can read it but has no way to change it. The second is a 19-bit countdown timer that supervisory code loads to enforce a time limit. When the countdown reaches zero, it raises a time-signal request that is gated by the interrupt-system enable.

The millisecond strobe comes in on `tick_i`. A prescaler set by the parameter `TICK_DIV` passes one advance for every `TICK_DIV` strobes. This lets the input be tied to a faster periodic pulse, or held high so that every clock cycle counts. Reads go through one registered port. In a single cycle, that port captures either the complete elapsed count or the zero-extended countdown value.

Top module: `mp_time_base`

## Requirements
- R1: After reset, the elapsed counter, the countdown value, the pending time signal and `rd_data_o` are all zero, and `irq_o` is low.
- R2: Each advance (with the default `TICK_DIV` = 1, a cycle with `tick_i` = 1) adds one to the elapsed counter, which wraps modulo 2^36. The counter holds its value in every other cycle.
- R3: No input other than an advance changes the elapsed counter. In particular, countdown writes (`wr_en_i` = 1 with any `wr_data_i`) leave it unchanged.
- R4: A cycle with `wr_en_i` = 1 loads `wr_data_i` into the countdown. Any 19-bit value, including all ones, reads back unchanged.
- R5: On an advance without a write, a nonzero countdown value decreases by one. A countdown value of zero stays at zero and does not wrap.
- R6: An advance that takes the countdown from one to zero sets the pending time signal at that clock edge. `irq_o` is high exactly when the time signal is pending and `irq_en_i` = 1, with no extra register between `irq_en_i` and `irq_o`.
- R7: While `irq_en_i` = 0, a time signal that arrives stays pending. Raising `irq_en_i` later drives `irq_o` high in that same cycle.
- R8: A write clears the pending time signal. A write has priority over a same-cycle advance, so the loaded value is exactly `wr_data_i`. Loading zero does not raise a time signal.
- R9: A cycle with `rd_en_i` = 1 registers the elapsed counter (`rd_sel_i` = 0) or the countdown zero-extended to 36 bits (`rd_sel_i` = 1) into `rd_data_o` at the next edge. The value is the one held before any same-cycle advance. `rd_data_o` holds when `rd_en_i` = 0.
- R10: With `TICK_DIV` = N > 1, both counters advance once per N strobes of `tick_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Millisecond strobe fed to the prescaler |
| rd_en_i | input | 1 | Capture a counter into the read register |
| rd_sel_i | input | 1 | 0 selects elapsed counter, 1 selects countdown |
| rd_data_o | output | 36 | Registered read value |
| wr_en_i | input | 1 | Privileged countdown load |
| wr_data_i | input | 19 | Countdown load value |
| irq_en_i | input | 1 | Interrupt-system enable |
| irq_o | output | 1 | Time-signal interrupt request |

## Verification
Counter updates and the pending flag take effect at the clock edge that samples the advance or write. A captured read appears on `rd_data_o` one edge after `rd_en_i`, and it shows the counter value from before that edge. `irq_o` follows `irq_en_i` within the same cycle. The bench reference model updates its state at each rising edge from the inputs it sees there, then compares 3 ns later. At that point every registered output has settled, but the inputs, which change only on the falling edge, have not moved yet. Directed reads finish one full cycle after the read request, so each directed read checks the value captured at the intermediate edge.

// File: rtl/mp_time_pkg.sv
package mp_time_pkg;

  // Read source selection
  typedef enum logic {
    SEL_ELAPSED  = 1'b0,
    SEL_INTERVAL = 1'b1
  } rd_sel_e;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mp_rst_sync.sv
module mp_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/mp_tick_prescaler.sv
module mp_tick_prescaler #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic adv_o
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign adv_o = tick_i;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          at_last;

      assign at_last = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
          cnt_d = at_last ? '0 : cnt_q + CW'(1);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (tick_i) begin
          cnt_q <= cnt_d;
        end
      end

      assign adv_o = tick_i & at_last;
    end
  endgenerate
endmodule

// File: rtl/mp_elapsed_ctr.sv
module mp_elapsed_ctr #(
  parameter int unsigned EL_W = 36
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [EL_W-1:0] count_o
);
  logic [EL_W-1:0] cnt_q;
  logic [EL_W-1:0] cnt_d;

  // Wraps naturally at 2^EL_W
  always_comb begin
    cnt_d = cnt_q + EL_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/mp_interval_tmr.sv
module mp_interval_tmr #(
  parameter int unsigned IV_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            wr_en_i,
  input  logic [IV_W-1:0] wr_data_i,
  output logic [IV_W-1:0] count_o,
  output logic            pend_o
);
  logic [IV_W-1:0] cnt_q;
  logic [IV_W-1:0] cnt_d;
  logic            pend_q;
  logic            pend_d;
  logic            upd;
  logic            at_one;
  logic            nonzero;

  assign nonzero = |cnt_q;
  assign at_one  = (cnt_q == IV_W'(1));
  assign upd     = wr_en_i | (adv_i & nonzero);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (wr_en_i) begin
      cnt_d  = wr_data_i;
      pend_d = 1'b0;
    end else if (adv_i && nonzero) begin
      cnt_d = cnt_q - IV_W'(1);
      if (at_one) begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign count_o = cnt_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/mp_read_port.sv
module mp_read_port
  import mp_time_pkg::*;
#(
  parameter int unsigned EL_W = 36,
  parameter int unsigned IV_W = 19,
  parameter int unsigned RD_W = 36
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_en_i,
  input  rd_sel_e         sel_i,
  input  logic [EL_W-1:0] elapsed_i,
  input  logic [IV_W-1:0] interval_i,
  output logic [RD_W-1:0] rd_data_o
);
  logic [RD_W-1:0] rd_q;
  logic [RD_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (sel_i == SEL_ELAPSED) begin
      rd_d[EL_W-1:0] = elapsed_i;
    end else begin
      rd_d[IV_W-1:0] = interval_i;
    end
  end

  // Whole word captured at one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/mp_time_base.sv
module mp_time_base
  import mp_time_pkg::*;
#(
  parameter int unsigned EL_W     = 36,
  parameter int unsigned IV_W     = 19,
  parameter int unsigned TICK_DIV = 1,
  localparam int unsigned RD_W    = max_w(EL_W, IV_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            rd_en_i,
  input  logic            rd_sel_i,
  output logic [RD_W-1:0] rd_data_o,
  input  logic            wr_en_i,
  input  logic [IV_W-1:0] wr_data_i,
  input  logic            irq_en_i,
  output logic            irq_o
);
  logic            rst_n_sync;
  logic            adv;
  logic [EL_W-1:0] elapsed;
  logic [IV_W-1:0] interval;
  logic            pending;
  rd_sel_e         sel;

  assign sel = rd_sel_e'(rd_sel_i);

  mp_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  mp_tick_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .tick_i (tick_i),
    .adv_o  (adv)
  );

  mp_elapsed_ctr #(.EL_W(EL_W)) u_el (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .adv_i   (adv),
    .count_o (elapsed)
  );

  mp_interval_tmr #(.IV_W(IV_W)) u_iv (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .adv_i     (adv),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .count_o   (interval),
    .pend_o    (pending)
  );

  mp_read_port #(.EL_W(EL_W), .IV_W(IV_W), .RD_W(RD_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .rd_en_i    (rd_en_i),
    .sel_i      (sel),
    .elapsed_i  (elapsed),
    .interval_i (interval),
    .rd_data_o  (rd_data_o)
  );

  assign irq_o = pending & irq_en_i;
endmodule

// File: rtl/mp_time_base_chk.sv
module mp_time_base_chk #(
  parameter int unsigned EL_W = 36,
  parameter int unsigned IV_W = 19,
  parameter int unsigned RD_W = 36
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            adv,
  input logic            rd_en_i,
  input logic            rd_sel_i,
  input logic [RD_W-1:0] rd_data_o,
  input logic            wr_en_i,
  input logic [IV_W-1:0] wr_data_i,
  input logic            irq_o,
  input logic [EL_W-1:0] elapsed,
  input logic [IV_W-1:0] interval,
  input logic            pending
);
  AST_ELAPSED_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    adv |=> elapsed == $past(elapsed) + EL_W'(1)); // R2
  AST_ELAPSED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !adv |=> $stable(elapsed)); // R3
  AST_IVL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i |=> interval == $past(wr_data_i)); // R4
  AST_IVL_DEC: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_en_i && adv && interval != '0) |=> interval == $past(interval) - IV_W'(1)); // R5
  AST_IVL_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_en_i && interval == '0) |=> interval == '0); // R5
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!wr_en_i && adv && interval == IV_W'(1)) |=> pending); // R6
  AST_IRQ_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> interval == '0); // R6
  AST_PEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pending && !wr_en_i) |=> pending); // R7
  AST_PEND_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i |=> !pending); // R8
  AST_RD_ELAPSED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_en_i && !rd_sel_i) |=> rd_data_o[EL_W-1:0] == $past(elapsed)); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o)); // R9
endmodule

bind mp_time_base mp_time_base_chk #(.EL_W(EL_W), .IV_W(IV_W), .RD_W(RD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_sync),
  .adv       (adv),
  .rd_en_i   (rd_en_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .elapsed   (elapsed),
  .interval  (interval),
  .pending   (pending)
);

// File: tb/mp_time_base_tb_top.sv
module mp_time_base_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        rd_sel_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [18:0] wr_data_i = '0;
  logic        irq_en_i = 1'b0;
  logic [35:0] rd_data_o;
  logic        irq_o;
  logic [35:0] rd_data_div;
  logic        irq_div;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit started = 1'b0;

  // reference model state
  logic [35:0] m_el;
  logic [18:0] m_iv;
  logic        m_pend;
  logic [35:0] m_rd;
  int          strobes;

  always #4 clk_i = ~clk_i;

  mp_time_base dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rd_en_i(rd_en_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .irq_en_i(irq_en_i), .irq_o(irq_o));

  mp_time_base #(.TICK_DIV(3)) dut_div_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rd_en_i(rd_en_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_div), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .irq_en_i(irq_en_i), .irq_o(irq_div));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // model update at edge, comparison 3 ns later
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_el = '0; m_iv = '0; m_pend = 1'b0; m_rd = '0; strobes = 0;
    end else begin
      if (rd_en_i) m_rd = rd_sel_i ? {17'd0, m_iv} : m_el;
      if (tick_i) begin
        m_el = m_el + 36'd1;
        strobes++;
      end
      if (wr_en_i) begin
        m_iv = wr_data_i;
        m_pend = 1'b0;
      end else if (tick_i && m_iv != 0) begin
        if (m_iv == 19'd1) m_pend = 1'b1;
        m_iv = m_iv - 19'd1;
      end
    end
    #3;
    if (started) begin
      check(rd_data_o == m_rd, {cur_req, " rd_data model"}, rd_data_o, m_rd);
      check(irq_o == (m_pend & irq_en_i), {cur_req, " irq model"}, irq_o, m_pend & irq_en_i);
    end
  end

  task automatic step(input bit tk, input bit wr, input logic [18:0] wd,
                      input bit rd, input bit sel);
    tick_i = tk; wr_en_i = wr; wr_data_i = wd; rd_en_i = rd; rd_sel_i = sel;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic read_chk(input bit sel, input logic [35:0] exp, input string req);
    step(1'b0, 1'b0, '0, 1'b1, sel);
    check(rd_data_o == exp, req, rd_data_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(rd_data_o == 36'd0, "R1 rd_data in reset", rd_data_o, 0);
    check(irq_o == 1'b0, "R1 irq in reset", irq_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    started = 1'b1;
    cur_req = "R1";
    read_chk(1'b0, 36'd0, "R1 elapsed after reset");
    read_chk(1'b1, 36'd0, "R1 interval after reset");

    // R2: advance and hold
    cur_req = "R2";
    ticks(5);
    read_chk(1'b0, 36'd5, "R2 elapsed after 5 ticks");
    repeat (3) @(negedge clk_i);
    read_chk(1'b0, 36'd5, "R2 elapsed holds without tick");

    // R3 / R4: writes leave elapsed alone, load any value
    cur_req = "R3";
    step(1'b0, 1'b1, 19'h7FFFF, 1'b0, 1'b0);
    read_chk(1'b0, 36'd5, "R3 elapsed after interval write");
    cur_req = "R4";
    read_chk(1'b1, 36'h7FFFF, "R4 interval all ones");
    step(1'b0, 1'b1, 19'd7, 1'b0, 1'b0);
    read_chk(1'b1, 36'd7, "R4 interval loaded 7");

    // R5 / R7: countdown with interrupts disabled
    cur_req = "R5";
    irq_en_i = 1'b0;
    ticks(6);
    read_chk(1'b1, 36'd1, "R5 interval after 6 ticks");
    cur_req = "R7";
    ticks(1);
    check(irq_o == 1'b0, "R7 irq masked while disabled", irq_o, 0);
    ticks(2);
    cur_req = "R5";
    read_chk(1'b1, 36'd0, "R5 interval floors at zero");
    cur_req = "R7";
    irq_en_i = 1'b1;
    #1;
    check(irq_o == 1'b1, "R7 pending shown on enable", irq_o, 1);
    @(negedge clk_i);

    // R8: write beats tick, clears pending
    cur_req = "R8";
    step(1'b1, 1'b1, 19'd3, 1'b0, 1'b0);
    check(irq_o == 1'b0, "R8 write clears pending", irq_o, 0);
    read_chk(1'b1, 36'd3, "R8 write wins over tick");

    // R6: enabled countdown raises irq on the edge reaching zero
    cur_req = "R6";
    ticks(2);
    check(irq_o == 1'b0, "R6 irq low at count 1", irq_o, 0);
    ticks(1);
    check(irq_o == 1'b1, "R6 irq high at zero", irq_o, 1);

    // R8: loading zero raises nothing
    cur_req = "R8";
    step(1'b0, 1'b1, 19'd0, 1'b0, 1'b0);
    repeat (2) @(negedge clk_i);
    check(irq_o == 1'b0, "R8 zero load no irq", irq_o, 0);

    // R9: atomic capture before same-cycle tick, hold, zero extension
    cur_req = "R9";
    step(1'b1, 1'b0, '0, 1'b1, 1'b0);
    check(rd_data_o == 36'd18, "R9 read same cycle as tick", rd_data_o, 18);
    read_chk(1'b0, 36'd19, "R9 read after tick");
    repeat (3) @(negedge clk_i);
    check(rd_data_o == 36'd19, "R9 read data holds", rd_data_o, 19);
    step(1'b0, 1'b1, 19'h40001, 1'b0, 1'b0);
    read_chk(1'b1, 36'h40001, "R9 interval zero-extended");

    // R10: divided advance on second instance
    cur_req = "R10";
    ticks(7);
    step(1'b0, 1'b0, '0, 1'b1, 1'b0);
    check(rd_data_div == 36'(strobes / 3), "R10 divided elapsed", rd_data_div, strobes / 3);
    check(rd_data_o == 36'(strobes), "R10 undivided elapsed", rd_data_o, strobes);

    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule